// File: doc/BRIEF.md
# Video Memory Read Prefetch Latch

This block serves host reads from video memory through a single-word prefetch latch. When the host writes a read setup through the control port, the block takes the word address and arms a fetch. It then waits for an external memory slot that is free and that no queued write claims. In that slot it issues one byte read. Because a word is two bytes, two such slots fill the latch. After the second byte arrives, a data-valid flag is raised.

A host data-port read is acknowledged only while the flag is set. The read returns the latched word, clears the flag, advances the address by the auto-increment value and re-arms the fetch. If the flag is clear, the acknowledge is withheld and the host stalls. If the current access mode is a write, no fetch is ever made, so the host stays stalled until reset or a new read setup.

The write FIFO, the slot generator and the memory are outside this block. The block sees them only through a slot-free strobe, a write-pending flag and a byte read port whose data returns in the same cycle.

Top module: `rpf_read_prefetch`

## Requirements
- R1: While reset is asserted and after it is released, the access mode is write, the data-valid flag is clear, `mem_rd_en` is low and `host_ack` is low.
- R2: After a read setup, `mem_rd_en` is raised in exactly those cycles where `slot_free` is high, `wr_pending` is low, no setup is being written and the latch is not yet full.
- R3: A cycle with `slot_free` high and `wr_pending` high never carries a prefetch read.
- R4: A word at word address A is fetched as byte address {A,0} first, which fills bits 15:8, then byte address {A,1}, which fills bits 7:0. The flag rises only after the second byte.
- R5: A host read while the flag is set is acknowledged in the same cycle, with `host_rdata` equal to the latched word.
- R6: A host read while the flag is clear gets no acknowledge. The stall lasts until the flag rises.
- R7: An acknowledged read clears the flag, adds `incr` to the word address (modulo 2^AW) and restarts the prefetch at byte 0 of the new address.
- R8: A new setup clears the flag and discards a half-filled word. The next fetch starts at byte 0 of the setup address.
- R9: In write mode (`setup_is_read` = 0 at the last setup), no prefetch read is issued and `host_ack` never rises, whatever `slot_free` and `host_rd_req` do.
- R10: While the flag is set, no prefetch read is issued.
- R11: A host read in the same cycle as a setup write is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_valid | input | 1 | Control-port setup written this cycle |
| setup_is_read | input | 1 | 1 = read access mode, 0 = write mode |
| setup_addr | input | AW | Word address carried by the setup |
| incr | input | IW | Auto-increment added after each acknowledged read |
| slot_free | input | 1 | An external memory slot is available this cycle |
| wr_pending | input | 1 | The write queue holds an entry and claims the slot |
| mem_rd_en | output | 1 | Byte read issued in this slot |
| mem_rd_addr | output | AW+1 | Byte address: word address with byte select as LSB |
| mem_rd_data | input | 8 | Byte returned in the same cycle |
| host_rd_req | input | 1 | Host data-port read pending |
| host_ack | output | 1 | Read completes this cycle |
| host_rdata | output | 16 | Word returned to the host |

## Verification
The bench holds a host read against a write-mode setup for a long stretch. A design that fetched regardless of mode would acknowledge it with made-up data. It also keeps `wr_pending` high across many free slots, where a design that did not yield would steal the slot from the write queue. A setup lands between the two byte fetches to catch a design that keeps the stale high byte or resumes at byte 1. An increment that crosses the top of the address space, together with a setup in the same cycle as a host read, checks wrap handling and the rule that the setup wins.

// File: rtl/rpf_pkg.sv
package rpf_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic {
        MODE_WRITE = 1'b0,
        MODE_READ  = 1'b1
    } access_mode_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              phase;
        logic              valid;
    } latch_state_t;
endpackage

// File: rtl/rpf_slot_arb.sv
module rpf_slot_arb (
    input  logic want,
    input  logic slot_free,
    input  logic wr_pending,
    output logic grant
);
    // queued writes own any free slot they want
    always_comb begin
        grant = want && slot_free && !wr_pending;
    end

    always_comb begin
        assert_write_first_R3: assert (!(grant && wr_pending))
            else $error("prefetch took a slot claimed by a write");
    end
endmodule

// File: rtl/rpf_word_latch.sv
module rpf_word_latch
    import rpf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              valid,
    output logic              phase,
    output logic [WORD_W-1:0] word
);
    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.valid = 1'b0;
            st_d.phase = 1'b0;
        end else if (load && !st_q.valid) begin
            if (!st_q.phase) begin
                st_d.word[WORD_W-1:BYTE_W] = byte_in;
                st_d.phase = 1'b1;
            end else begin
                st_d.word[BYTE_W-1:0] = byte_in;
                st_d.phase = 1'b0;
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.valid;
    assign phase = st_q.phase;
    assign word  = st_q.word;

    assert_valid_after_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.valid) |-> ($past(load) && $past(st_q.phase)));

    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!st_q.valid && !st_q.phase));
endmodule

// File: rtl/rpf_read_prefetch.sv
module rpf_read_prefetch
    import rpf_pkg::*;
#(
    parameter int AW = 16,
    parameter int IW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              setup_valid,
    input  logic              setup_is_read,
    input  logic [AW-1:0]     setup_addr,
    input  logic [IW-1:0]     incr,
    input  logic              slot_free,
    input  logic              wr_pending,
    output logic              mem_rd_en,
    output logic [AW:0]       mem_rd_addr,
    input  logic [BYTE_W-1:0] mem_rd_data,
    input  logic              host_rd_req,
    output logic              host_ack,
    output logic [WORD_W-1:0] host_rdata
);
    localparam int EXT_W = AW - IW;

    typedef struct packed {
        logic [AW-1:0] addr;
        access_mode_e  mode;
    } ctrl_state_t;

    ctrl_state_t ctl_d, ctl_q;
    logic        lat_valid, lat_phase, want, grant, consume;
    logic [AW-1:0] incr_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign incr_ext = {{EXT_W{1'b0}}, incr};
        end else begin : g_trunc
            assign incr_ext = incr[AW-1:0];
        end
    endgenerate

    always_comb begin
        consume = host_rd_req && lat_valid && (ctl_q.mode == MODE_READ) && !setup_valid;
        want    = (ctl_q.mode == MODE_READ) && !lat_valid && !setup_valid;
        ctl_d   = ctl_q;
        if (setup_valid) begin
            ctl_d.addr = setup_addr;
            ctl_d.mode = setup_is_read ? MODE_READ : MODE_WRITE;
        end else if (consume) begin
            ctl_d.addr = ctl_q.addr + incr_ext;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.addr <= '0;
            ctl_q.mode <= MODE_WRITE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    rpf_slot_arb u_arb (
        .want       (want),
        .slot_free  (slot_free),
        .wr_pending (wr_pending),
        .grant      (grant)
    );

    rpf_word_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (setup_valid || consume),
        .load    (grant),
        .byte_in (mem_rd_data),
        .valid   (lat_valid),
        .phase   (lat_phase),
        .word    (host_rdata)
    );

    assign mem_rd_en   = grant;
    assign mem_rd_addr = {ctl_q.addr, lat_phase};
    assign host_ack    = consume;

    assert_no_fetch_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lat_valid |-> !mem_rd_en);

    assert_ack_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> lat_valid);

    assert_write_mode_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == MODE_WRITE) |-> (!mem_rd_en && !host_ack));

    assert_ack_advances_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> (!lat_valid && ctl_q.addr == $past(ctl_q.addr + incr_ext)));

    assert_setup_blocks_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        setup_valid |-> !host_ack);
endmodule

// File: tb/rpf_read_prefetch_bench.sv
module rpf_read_prefetch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int IW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic setup_valid = 0, setup_is_read = 0, slot_free = 0, wr_pending = 0, host_rd_req = 0;
    logic [AW-1:0] setup_addr = '0;
    logic [IW-1:0] incr = '0;
    logic mem_rd_en, host_ack;
    logic [AW:0] mem_rd_addr;
    logic [7:0] mem_rd_data;
    logic [15:0] host_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [AW:0] a);
        return (a[7:0] * 8'd37) ^ a[AW:AW-7] ^ 8'h5A;
    endfunction

    assign mem_rd_data = mem_byte(mem_rd_addr);

    rpf_read_prefetch #(.AW(AW), .IW(IW)) u_rpf_read_prefetch (
        .clk(clk), .rst_n(rst_n), .setup_valid(setup_valid), .setup_is_read(setup_is_read),
        .setup_addr(setup_addr), .incr(incr), .slot_free(slot_free), .wr_pending(wr_pending),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .host_rd_req(host_rd_req), .host_ack(host_ack), .host_rdata(host_rdata)
    );

    // reference model state
    bit m_mode = 0, m_valid = 0, m_phase = 0, m_src_incr = 0, m_discard = 0;
    logic [AW-1:0] m_addr = '0;
    logic [15:0] m_word = '0;
    int checks = 0, fails = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit su, input bit su_rd, input logic [AW-1:0] sa,
                        input bit sf, input bit wp, input bit hr, input logic [IW-1:0] inc);
        bit exp_fetch, exp_ack;
        string ftag, atag, ktag;
        @(negedge clk);
        setup_valid = su; setup_is_read = su_rd; setup_addr = sa;
        slot_free = sf; wr_pending = wp; host_rd_req = hr; incr = inc;
        #2;
        exp_fetch = m_mode && !m_valid && !su && sf && !wp;
        exp_ack   = hr && m_valid && m_mode && !su;
        if (!m_mode) ftag = "R9";
        else if (sf && wp) ftag = "R3";
        else if (m_valid) ftag = "R10";
        else ftag = "R2";
        if (su) ktag = "R11";
        else if (!m_mode) ktag = "R9";
        else if (!m_valid) ktag = "R6";
        else ktag = "R5";
        atag = m_discard ? "R8" : (m_src_incr ? "R7" : "R4");
        check(mem_rd_en === exp_fetch, ftag, "mem_rd_en", 32'(mem_rd_en), 32'(exp_fetch));
        if (exp_fetch)
            check(mem_rd_addr === {m_addr, m_phase}, atag, "mem_rd_addr",
                  32'(mem_rd_addr), 32'({m_addr, m_phase}));
        check(host_ack === exp_ack, ktag, "host_ack", 32'(host_ack), 32'(exp_ack));
        if (exp_ack)
            check(host_rdata === m_word, "R5", "host_rdata", 32'(host_rdata), 32'(m_word));
        // model update for the coming edge
        if (su) begin
            m_discard = m_valid || m_phase;
            m_mode = su_rd; m_addr = sa; m_valid = 0; m_phase = 0; m_src_incr = 0;
        end else if (exp_ack) begin
            m_valid = 0; m_phase = 0; m_addr = m_addr + AW'(inc); m_src_incr = 1; m_discard = 0;
        end else if (exp_fetch) begin
            if (!m_phase) begin
                m_word[15:8] = mem_byte({m_addr, 1'b0}); m_phase = 1;
            end else begin
                m_word[7:0] = mem_byte({m_addr, 1'b1}); m_phase = 0; m_valid = 1;
            end
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hang expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state with traffic offered
        @(negedge clk);
        slot_free = 1; host_rd_req = 1;
        #2;
        check(mem_rd_en === 1'b0, "R1", "mem_rd_en in reset", 32'(mem_rd_en), 0);
        check(host_ack === 1'b0, "R1", "host_ack in reset", 32'(host_ack), 0);
        @(negedge clk); rst_n = 1;
        #2;
        check(mem_rd_en === 1'b0, "R1", "mem_rd_en after reset", 32'(mem_rd_en), 0);
        check(host_ack === 1'b0, "R1", "host_ack after reset", 32'(host_ack), 0);

        // R9: write mode hangs the host read
        step(1, 0, 16'h0040, 1, 0, 1, 8'd1);
        for (int i = 0; i < 40; i++) step(0, 0, '0, 1, 0, 1, 8'd1);

        // R2, R3: read setup with the write queue hogging every free slot
        step(1, 1, 16'h1234, 1, 1, 1, 8'd2);
        for (int i = 0; i < 20; i++) step(0, 0, '0, 1, 1, 1, 8'd2);
        // R4, R5, R6: release queue, word assembles, host collects
        for (int i = 0; i < 8; i++) step(0, 0, '0, 1, 0, 1, 8'd2);

        // R8: setup between the two byte fetches
        step(1, 1, 16'h0100, 1, 0, 0, 8'd1);
        step(0, 0, '0, 1, 0, 0, 8'd1);
        step(1, 1, 16'h0200, 1, 0, 0, 8'd1);
        for (int i = 0; i < 4; i++) step(0, 0, '0, 1, 0, 1, 8'd1);

        // R7: increment wraps past the top of the address space
        step(1, 1, 16'hFFFE, 1, 0, 0, 8'd3);
        for (int i = 0; i < 8; i++) step(0, 0, '0, 1, 0, 1, 8'd3);

        // R11: setup written in the same cycle as a host read with data ready
        step(1, 1, 16'h0300, 1, 0, 0, 8'd1);
        step(0, 0, '0, 1, 0, 0, 8'd1);
        step(0, 0, '0, 1, 0, 0, 8'd1);
        step(1, 1, 16'h0400, 1, 0, 1, 8'd1);
        for (int i = 0; i < 4; i++) step(0, 0, '0, 1, 0, 1, 8'd1);

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            int r;
            bit su, rd;
            r  = $urandom_range(999);
            su = (r < 25);
            rd = (r >= 5);
            step(su, rd, AW'($urandom), ($urandom_range(99) < 50), ($urandom_range(99) < 30),
                 ($urandom_range(99) < 40), IW'($urandom_range(4)));
        end
        finish_run();
    end
endmodule